// File: doc/BRIEF.md
# Programmable 3x3 Colour-Space Conversion Matrix

This unit sits in a pixel pipeline and turns each incoming RGB pixel into three new output channels. Each input channel first receives its own signed pre-offset. The three adjusted values are then multiplied by a row of the 3x3 coefficient matrix and summed. A signed post-offset is added per output row. The result is rounded to the pixel width and clamped to the legal range. Pixels arrive and leave as 10-bit-per-channel words, each qualified by a valid strobe. The output follows the input at a fixed latency with no backpressure.

Coefficients are not plain fixed-point numbers. Each one is a 16-bit word: a sign bit, a 3-bit range code and a 9-bit magnitude mantissa. The range code slides the mantissa's binary point, so small coefficients keep fine resolution and large ones still reach almost 4.0. Software writes a set of staging registers through a simple write port. Nothing it writes reaches the datapath until a frame-start strobe copies the whole staging set into the working set. Each pixel therefore sees one consistent configuration from start to end.

A mode word can switch the unit to pass-through. In that mode the pixels keep the same latency and leave unchanged.

Top module: `csc_matrix`

## Requirements
- R1: After reset the output valid is low. The working configuration is the identity matrix (diagonal word 0x7800, all other coefficients zero), all offsets are zero and the mode is matrix, so a pixel leaves unchanged.
- R2: A pixel sampled with `in_valid` high on one rising edge appears with `out_valid` high after the third rising edge, counting the sampling edge as the first. `out_valid` repeats the `in_valid` pattern exactly, gaps included.
- R3: Coefficient word layout: bit 15 is the sign (1 = negative), bits 14:12 are the range code, bits 11:3 are the mantissa M, and bits 2:0 are ignored. The magnitude is M/4096 for code 3, M/2048 for code 2, M/1024 for code 1, M/512 for code 0, M/256 for code 7 and M/128 for code 6.
- R4: Range codes 4 and 5 are reserved and decode as a zero coefficient.
- R5: Write address map. Row k (0,1,2 producing `out_c0..2`) keeps its R and G coefficients at address 2k: R in bits 31:16, G in bits 15:0. Its B coefficient is at address 2k+1, bits 31:16; bits 15:0 of that word are ignored. Writes to addresses 13 to 15 change nothing.
- R6: Pre-offsets for the R, G and B inputs are at addresses 6, 7 and 8. Each is a 13-bit two's-complement value in bits 12:0, in units of 1/4096 of full scale (4 units per pixel step). It is added to its input channel before the multiply.
- R7: Post-offsets for output rows 0, 1 and 2 are at addresses 9, 10 and 11. They use the same 13-bit signed format and units as R6 and are added to the row sum.
- R8: Each row result is rounded half-up to a whole pixel step, then clamped: negative values give 0 and values above 1023 give 1023.
- R9: Writes land in staging registers only. A `frame_start` pulse copies the whole staging set into the working set. A pixel sampled on the same edge as the pulse is processed entirely with the old set. A pixel sampled on any later edge is processed entirely with the new set.
- R10: Mode word at address 12. Bit 0 set selects pass-through, where `out_c0..2` equal `in_r`, `in_g` and `in_b` at the R2 latency. Bit 0 clear selects the matrix. All other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Commits staging registers to the working set |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | 10 | Input red channel |
| in_g | input | 10 | Input green channel |
| in_b | input | 10 | Input blue channel |
| out_valid | output | 1 | Output pixel valid |
| out_c0 | output | 10 | Output channel of matrix row 0 |
| out_c1 | output | 10 | Output channel of matrix row 1 |
| out_c2 | output | 10 | Output channel of matrix row 2 |

## Verification
A wrongly decoded range code or mantissa shows up three edges after the first pixel that uses that coefficient. It appears as an output off by a power-of-two factor, or stuck at 0 or 1023. A configuration stage that is out of step with the pixel stages only shows on pixels sampled next to a `frame_start` pulse. There, one pixel mixes the offsets of one set with the matrix of the other. The bench therefore sends pixels on the commit edge and on the edge after it. A broken valid chain or a bad rounding boundary is visible on the first affected pixel. The rounding case uses pixels whose exact result lies on a half step.

// File: rtl/csc_pkg.sv
package csc_pkg;

    // Coefficient word format
    localparam int COEF_W    = 16;
    localparam int SIGN_BIT  = 15;
    localparam int CODE_HI   = 14;
    localparam int CODE_LO   = 12;
    localparam int MANT_HI   = 11;
    localparam int MANT_LO   = 3;
    localparam int MANT_W    = MANT_HI - MANT_LO + 1;
    localparam int COEF_FRAC = 12;              // decoded coefficient fraction bits
    localparam int MAX_SHIFT = 5;               // largest mantissa shift (range code 6)
    localparam int COEF_Q_W  = MANT_W + MAX_SHIFT + 1;

    // Offset format
    localparam int OFS_W     = 13;
    localparam int OFS_FRAC  = 12;

    // Matrix geometry
    localparam int NCH       = 3;

    // Register map
    localparam int PRE_BASE  = 6;
    localparam int POST_BASE = 9;
    localparam int MODE_ADDR = 12;

    localparam logic [COEF_W-1:0] COEF_ONE = 16'h7800;

    typedef enum logic [2:0] {
        RANGE_LT_1    = 3'd0,
        RANGE_LT_HALF = 3'd1,
        RANGE_LT_QTR  = 3'd2,
        RANGE_LT_8TH  = 3'd3,
        RANGE_RSV_A   = 3'd4,
        RANGE_RSV_B   = 3'd5,
        RANGE_LT_4    = 3'd6,
        RANGE_LT_2    = 3'd7
    } range_code_e;

    typedef enum logic {
        MODE_MATRIX = 1'b0,
        MODE_BYPASS = 1'b1
    } op_mode_e;

    typedef logic signed [COEF_Q_W-1:0] coef_q_t;

    typedef struct packed {
        logic [NCH*NCH-1:0][COEF_W-1:0] coef;   // index row*NCH + input column
        logic [NCH-1:0][OFS_W-1:0]      pre;
        logic [NCH-1:0][OFS_W-1:0]      post;
        op_mode_e                       mode;
    } cfg_t;

    function automatic cfg_t cfg_default();
        cfg_t c;
        c = '0;
        for (int r = 0; r < NCH; r++) begin
            c.coef[r*NCH + r] = COEF_ONE;
        end
        c.mode = MODE_MATRIX;
        return c;
    endfunction

endpackage

// File: rtl/csc_coef_decode.sv
module csc_coef_decode
    import csc_pkg::*;
(
    input  logic [COEF_W-1:0] word,
    output coef_q_t           value
);

    localparam int MAG_W = COEF_Q_W - 1;

    logic [MANT_W-1:0] mant;
    logic [MAG_W-1:0]  mag;
    range_code_e       code;
    logic              unused_pad;

    assign mant       = word[MANT_HI:MANT_LO];
    assign code       = range_code_e'(word[CODE_HI:CODE_LO]);
    assign unused_pad = ^word[MANT_LO-1:0];

    always_comb begin
        unique case (code)
            RANGE_LT_8TH:  mag = MAG_W'(mant);
            RANGE_LT_QTR:  mag = MAG_W'(mant) << 1;
            RANGE_LT_HALF: mag = MAG_W'(mant) << 2;
            RANGE_LT_1:    mag = MAG_W'(mant) << 3;
            RANGE_LT_2:    mag = MAG_W'(mant) << 4;
            RANGE_LT_4:    mag = MAG_W'(mant) << 5;
            RANGE_RSV_A:   mag = '0;
            RANGE_RSV_B:   mag = '0;
        endcase
    end

    assign value = word[SIGN_BIT] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

endmodule

// File: rtl/csc_cfg_bank.sv
module csc_cfg_bank
    import csc_pkg::*;
#(
    parameter int ADDR_W = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              frame_start,
    output cfg_t              live
);

    cfg_t staging;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staging <= cfg_default();
            live    <= cfg_default();
        end else begin
            if (frame_start) begin
                live <= staging;
            end
            if (reg_wr) begin
                for (int r = 0; r < NCH; r++) begin
                    if (reg_addr == ADDR_W'(2*r)) begin
                        staging.coef[r*NCH + 0] <= reg_wdata[31:16];
                        staging.coef[r*NCH + 1] <= reg_wdata[15:0];
                    end
                    if (reg_addr == ADDR_W'(2*r + 1)) begin
                        staging.coef[r*NCH + 2] <= reg_wdata[31:16];
                    end
                    if (reg_addr == ADDR_W'(PRE_BASE + r)) begin
                        staging.pre[r] <= reg_wdata[OFS_W-1:0];
                    end
                    if (reg_addr == ADDR_W'(POST_BASE + r)) begin
                        staging.post[r] <= reg_wdata[OFS_W-1:0];
                    end
                end
                if (reg_addr == ADDR_W'(MODE_ADDR)) begin
                    staging.mode <= op_mode_e'(reg_wdata[0]);
                end
            end
        end
    end

    AST_WORKING_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(live)); // R9

    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr > ADDR_W'(MODE_ADDR)) |=> $stable(staging)); // R5

endmodule

// File: rtl/csc_row_mac.sv
module csc_row_mac
    import csc_pkg::*;
#(
    parameter int PIX_W = 10,
    parameter int XW    = 14,
    parameter int SHIFT = 14
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_s2,
    input  logic signed [XW-1:0]    x_s1 [NCH],
    input  coef_q_t                 coef [NCH],
    input  logic [OFS_W-1:0]        post,
    input  logic                    bypass,
    input  logic [PIX_W-1:0]        raw_s2,
    output logic [PIX_W-1:0]        pix_out
);

    localparam int PROD_W = XW + COEF_Q_W;
    localparam int ACC_W  = PROD_W + 2;
    localparam int TOT_W  = ACC_W + 1;

    logic signed [ACC_W-1:0] sum_c;
    logic signed [ACC_W-1:0] sum_s2;
    logic signed [TOT_W-1:0] tot;
    logic signed [TOT_W-1:0] scaled;
    logic [PIX_W-1:0]        sat;
    logic [PIX_W-1:0]        pix_next;

    // Stage 2: three products summed at full width
    always_comb begin
        sum_c = '0;
        for (int k = 0; k < NCH; k++) begin
            sum_c = sum_c + ACC_W'(x_s1[k]) * ACC_W'(coef[k]);
        end
    end

    always_ff @(posedge clk) begin
        sum_s2 <= sum_c;
    end

    // Stage 3: post-offset, round half-up, clamp
    assign tot    = TOT_W'(sum_s2)
                  + (TOT_W'($signed(post)) <<< COEF_FRAC)
                  + (TOT_W'(1) <<< (SHIFT - 1));
    assign scaled = tot >>> SHIFT;

    always_comb begin
        if (scaled[TOT_W-1]) begin
            sat = '0;
        end else if (|scaled[TOT_W-2:PIX_W]) begin
            sat = '1;
        end else begin
            sat = scaled[PIX_W-1:0];
        end
    end

    assign pix_next = bypass ? raw_s2 : sat;

    always_ff @(posedge clk) begin
        pix_out <= pix_next;
    end

    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_s2 && !bypass && tot < 0) |=> (pix_out == '0)); // R8

    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_s2 && !bypass && !scaled[TOT_W-1] && (|scaled[TOT_W-2:PIX_W]))
        |=> (pix_out == '1)); // R8

    AST_BYPASS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_s2 && bypass) |=> (pix_out == $past(raw_s2))); // R10

endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
    import csc_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int ADDR_W = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_r,
    input  logic [PIX_W-1:0]  in_g,
    input  logic [PIX_W-1:0]  in_b,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_c0,
    output logic [PIX_W-1:0]  out_c1,
    output logic [PIX_W-1:0]  out_c2
);

    localparam int PIX_SHIFT = OFS_FRAC - PIX_W;
    localparam int XW        = OFS_FRAC + 2;
    localparam int RND_SHIFT = COEF_FRAC + PIX_SHIFT;

    // Configuration: staging and working set
    cfg_t live;

    csc_cfg_bank #(.ADDR_W(ADDR_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .frame_start (frame_start),
        .live        (live)
    );

    // Coefficient decode, one decoder per matrix entry
    coef_q_t dec_c [NCH*NCH];
    coef_q_t dec_s [NCH*NCH];

    for (genvar i = 0; i < NCH*NCH; i++) begin : g_dec
        csc_coef_decode u_dec (
            .word  (live.coef[i]),
            .value (dec_c[i])
        );
    end

    // Configuration travels one stage behind per pipeline stage
    logic [NCH-1:0][OFS_W-1:0] post_b, post_c;
    op_mode_e                  mode_b, mode_c;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH*NCH; i++) begin
            dec_s[i] <= dec_c[i];
        end
        post_b <= live.post;
        mode_b <= live.mode;
        post_c <= post_b;
        mode_c <= mode_b;
    end

    // Stage 1: scale input to offset units and add pre-offset
    logic [PIX_W-1:0]     pix_in [NCH];
    logic [PIX_W-1:0]     raw_s1 [NCH];
    logic [PIX_W-1:0]     raw_s2 [NCH];
    logic signed [XW-1:0] x_s1   [NCH];
    logic                 v_s1, v_s2;

    assign pix_in[0] = in_r;
    assign pix_in[1] = in_g;
    assign pix_in[2] = in_b;

    always_ff @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            x_s1[c]   <= (XW'($signed({1'b0, pix_in[c]})) <<< PIX_SHIFT)
                       + XW'($signed(live.pre[c]));
            raw_s1[c] <= pix_in[c];
            raw_s2[c] <= raw_s1[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_s1      <= 1'b0;
            v_s2      <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v_s1      <= in_valid;
            v_s2      <= v_s1;
            out_valid <= v_s2;
        end
    end

    // Stages 2 and 3: one multiply-accumulate row per output channel
    logic [PIX_W-1:0] pix_o [NCH];
    logic             bypass_c;

    assign bypass_c = (mode_c == MODE_BYPASS);

    for (genvar r = 0; r < NCH; r++) begin : g_row
        coef_q_t row_coef [NCH];
        for (genvar k = 0; k < NCH; k++) begin : g_col
            assign row_coef[k] = dec_s[r*NCH + k];
        end
        csc_row_mac #(
            .PIX_W (PIX_W),
            .XW    (XW),
            .SHIFT (RND_SHIFT)
        ) u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid_s2 (v_s2),
            .x_s1     (x_s1),
            .coef     (row_coef),
            .post     (post_c[r]),
            .bypass   (bypass_c),
            .raw_s2   (raw_s2[r]),
            .pix_out  (pix_o[r])
        );
    end

    assign out_c0 = pix_o[0];
    assign out_c1 = pix_o[1];
    assign out_c2 = pix_o[2];

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid); // R2

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid); // R2

endmodule

// File: tb/csc_matrix_test.sv
module csc_matrix_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [9:0]  in_r = '0, in_g = '0, in_b = '0;
    logic        out_valid;
    logic [9:0]  out_c0, out_c1, out_c2;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Table for matrix A: row0 = .5R+.25G+.125B, row1 = -.5R + post .5, row2 = 2G
    localparam int NVEC = 7;
    localparam int VEC [NVEC][6] = '{
        '{   0,    0,    0,   0, 512,    0},
        '{1023, 1023, 1023, 895,   1, 1023},
        '{ 100,  200,  300, 138, 462,  400},
        '{   1,    0,    0,   1, 512,    0},
        '{   0,  512,    0, 128, 512, 1023},
        '{ 511,  511,    0, 383, 257, 1022},
        '{   3,    5,    7,   4, 511,   10}
    };
    localparam logic [9:0] VPAT = 10'b0011011001;

    csc_matrix uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .frame_start(frame_start), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid),
        .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
    );

    always #5 clk = ~clk;

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a[3:0]; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic load_identity();
        wr(0, 32'h7800_0000); wr(1, 32'h0);
        wr(2, 32'h0000_7800); wr(3, 32'h0);
        wr(4, 32'h0);         wr(5, 32'h7800_0000);
        for (int a = 6; a <= 12; a++) wr(a, 32'h0);
    endtask

    task automatic check_px(input string req, input int r, input int g, input int b,
                            input int e0, input int e1, input int e2);
        @(negedge clk);
        in_valid = 1'b1; in_r = r[9:0]; in_g = g[9:0]; in_b = b[9:0];
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " c0"}, int'(out_c0), e0);
        chk({req, " c1"}, int'(out_c1), e1);
        chk({req, " c2"}, int'(out_c2), e2);
    endtask

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        chk("R1 valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid after reset", int'(out_valid), 0);
        check_px("R1 identity", 123, 456, 789, 123, 456, 789);

        // R2: valid pattern with gaps
        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            if (i >= 3) chk("R2 valid pattern", int'(out_valid), (i - 3 < 10) ? int'(VPAT[i-3]) : 0);
            in_valid = (i < 10) ? VPAT[i] : 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);

        // R3 R7 R8: table walk with matrix A
        wr(0, 32'h0800_1800); wr(1, 32'h2800_0000);
        wr(2, 32'h8800_0000); wr(3, 32'h0);
        wr(4, 32'h0000_6800); wr(5, 32'h0);
        wr(10, 32'h0000_0800);
        commit();
        for (int i = 0; i < NVEC; i++) begin
            check_px("R3/R7/R8 table", VEC[i][0], VEC[i][1], VEC[i][2],
                     VEC[i][3], VEC[i][4], VEC[i][5]);
        end

        // R3: smallest range code and ignored low bits
        load_identity();
        wr(0, 32'h3FF8_0000); wr(2, 32'h0000_7807);
        commit();
        check_px("R3 fine code and pad bits", 1023, 300, 5, 128, 300, 5);

        // R4: reserved range codes decode as zero
        wr(0, 32'h4800_0000); wr(2, 32'h0000_5800);
        commit();
        check_px("R4 reserved codes", 500, 500, 7, 0, 0, 7);

        // R5: B lower half and unmapped addresses ignored
        load_identity();
        wr(0, 32'h0800_0000); wr(1, 32'h0000_7800);
        wr(13, 32'hFFFF_FFFF); wr(15, 32'h7800_7801);
        commit();
        check_px("R5 map", 40, 50, 60, 20, 50, 60);

        // R6: pre-offsets (-256 and +256 pixel steps)
        load_identity();
        wr(6, 32'h0000_1C00); wr(8, 32'h0000_0400);
        commit();
        check_px("R6 pre-offset", 300, 7, 900, 44, 7, 1023);
        check_px("R6 R8 pre-offset clamp", 100, 0, 0, 0, 0, 256);

        // R7: post-offsets (+64 and -64 pixel steps)
        load_identity();
        wr(9, 32'h0000_0100); wr(11, 32'h0000_1F00);
        commit();
        check_px("R7 post-offset", 10, 20, 100, 74, 20, 36);

        // R9: staging writes hidden until frame start
        wr(9, 32'h0); wr(11, 32'h0);
        check_px("R9 before commit", 10, 20, 100, 74, 20, 36);
        @(negedge clk);
        frame_start = 1'b1; in_valid = 1'b1; in_r = 10'd10; in_g = 10'd20; in_b = 10'd100;
        @(negedge clk);
        frame_start = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R9 same-edge pixel c0", int'(out_c0), 74);
        chk("R9 same-edge pixel c2", int'(out_c2), 36);
        @(negedge clk);
        chk("R9 next pixel c0", int'(out_c0), 10);
        chk("R9 next pixel c2", int'(out_c2), 100);
        repeat (2) @(negedge clk);

        // R10: pass-through mode and ignored upper mode bits
        wr(0, 32'h0800_0000); wr(12, 32'h0000_0001);
        commit();
        check_px("R10 bypass", 200, 300, 400, 200, 300, 400);
        wr(12, 32'h0000_0002);
        commit();
        check_px("R10 matrix with bit1", 200, 300, 400, 100, 300, 400);

        summary();
    end

endmodule